// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Buffer Status

This block is the transmit half of a memory-mapped asynchronous serial port. Software sets the character format in a frame register: five to eight data bits, optional even or odd parity, and a stop period of half, one, one and a half or two bit times. Characters go into a two-entry holding buffer through a data register. A serializer takes them from the buffer and drives a line that is high when idle. Each bit lasts a fixed number of ticks of an external oversampling clock-enable, 16 by default.

The transmitter is switched on and off by write-one command pulses, not by a level bit. Status tells software whether the buffer can take more data and whether every character has left the line. Software can also read back whether the transmitter is switched on. An interrupt flag word holds the completion event and the buffer level. The completion flag is sticky and has separate set and clear write aliases. An enable mask reduces the flags to one interrupt line.

Registers are reached through a single-cycle write strobe and a combinational read port. The port uses word addresses: 0 control, 1 frame, 2 command, 3 status, 4 data, 5 flags, 6 flag set, 7 flag clear, 8 interrupt enable.

Top module: `uart_tx_port`

## Requirements
- R1: After reset the line is high and the interrupt output is low. Status reads 0x0040: the transmitter is off, complete is clear, and buffer-level is set because the buffer is empty. The flag word reads 0x0002.
- R2: A frame starts with one low start bit. The data bits follow, least significant first. Every bit lasts OSR baud ticks. The frame register field at bits 3:0 holds the data length minus 3, so 2 to 5 give 5 to 8 bits. Any other value gives 8 bits.
- R3: Frame bits 9:8 select parity: 00 or 01 none, 10 even, 11 odd. When parity is on, one parity bit follows the data. That bit makes the number of ones over the data and parity bits even or odd.
- R4: Frame bits 13:12 set the stop period, during which the line is high: 00 gives OSR/2 ticks, 01 gives OSR ticks, 10 gives 3·OSR/2 ticks and 11 gives 2·OSR ticks. The frame ends exactly after the data/parity bits plus the stop period.
- R5: A command write with bit 2 set switches the transmitter on. Bit 3 switches it off, and bit 3 wins if both are written at once. Status bit 1 shows whether the transmitter is on. When it is switched off, the character already on the line finishes, and buffered characters wait until it is switched on again.
- R6: The buffer holds two characters. A data write while both entries are full is dropped, and that character is never sent.
- R7: Status bit 6 (buffer-level) follows the buffer level. When control bit 12 is 0, it is high only when the buffer is empty. When control bit 12 is 1, it is high when at least one entry is free.
- R8: Status bit 5 (complete) goes high when a frame finishes its stop period and the buffer is empty. It stays high until the next data write, which clears it.
- R9: Flag bit 0 is set by the same completion event. It stays set until a 1 is written to bit 0 of the clear alias, and a 1 written to bit 0 of the set alias sets it. Flag bit 1 always equals buffer-level, and neither alias changes it.
- R10: The interrupt output is high exactly when some flag bit is 1 and the matching bit of the enable register (bits 1:0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| baud_tick | input | 1 | Oversampling clock-enable, OSR per bit |
| tx_out | output | 1 | Serial output, high when idle |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong internal state shows up on the line within one bit time. A wrong length or parity decode moves the following bit or the stop level at the next mid-bit sample. A stop counter that is off by one shows on the completion status bit in the tick where it changes, because status is read in the tick before the frame's end and again at the end. Buffer pointer or count errors show up as a duplicated, lost or extra character, or as a wrong buffer-level bit as soon as the write is made. Flag and mask errors appear on the interrupt pin in the cycle after the register write.

// File: rtl/uart_tx_port.sv
module uart_tx_port #(
  parameter int OSR = 16,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic          baud_tick,
  output logic          tx_out,
  output logic          irq
);
  localparam int TW = $clog2(2*OSR + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_FRAME = AW'(1), A_CMD  = AW'(2),
                            A_STAT = AW'(3), A_DATA  = AW'(4), A_FLAG = AW'(5),
                            A_FSET = AW'(6), A_FCLR  = AW'(7), A_FEN  = AW'(8);
  localparam logic [15:0] FRAME_MASK = 16'h330F;
  localparam logic [15:0] FRAME_RST  = 16'h1005;

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} phase_t;

  logic          bl_sel;
  logic [15:0]   frame_q;
  logic          en_q;
  logic [7:0]    buf_q [2];
  logic          wp, rp;
  logic [1:0]    cnt;
  phase_t        phase;
  logic [10:0]   sh;
  logic [3:0]    bits_left;
  logic [TW-1:0] tcnt, stop_q;
  logic          txc_stat, if_txc;
  logic [1:0]    ien;

  logic wr_data, push, load, done, txbl, cmp_event;
  logic [3:0]    dlen, nbits;
  logic [TW-1:0] stop_len;
  logic [10:0]   fv;
  logic          pbit;

  assign wr_data   = wr_en && addr == A_DATA;
  assign push      = wr_data && cnt != 2'd2;
  assign load      = phase == S_IDLE && en_q && cnt != 2'd0;
  assign done      = phase == S_STOP && baud_tick && tcnt == stop_q - TW'(1);
  assign cmp_event = done && cnt == 2'd0;
  assign txbl      = bl_sel ? (cnt != 2'd2) : (cnt == 2'd0);
  assign tx_out    = (phase == S_BITS) ? sh[0] : 1'b1;
  assign irq       = (if_txc & ien[0]) | (txbl & ien[1]);

  always_comb begin
    case (frame_q[3:0])
      4'd2, 4'd3, 4'd4, 4'd5: dlen = frame_q[3:0] + 4'd3;
      default:                dlen = 4'd8;
    endcase
    case (frame_q[13:12])
      2'b00:   stop_len = TW'(OSR/2);
      2'b01:   stop_len = TW'(OSR);
      2'b10:   stop_len = TW'(3*OSR/2);
      default: stop_len = TW'(2*OSR);
    endcase
    nbits = 4'd1 + dlen + {3'b000, frame_q[9]};
    fv    = '1;
    fv[0] = 1'b0;
    pbit  = frame_q[8];
    for (int i = 0; i < 8; i++) begin
      if (i < int'(dlen)) begin
        fv[i+1] = buf_q[rp][i];
        pbit    = pbit ^ buf_q[rp][i];
      end
    end
    if (frame_q[9]) fv[int'(dlen)+1] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_sel  <= 1'b0;
      frame_q <= FRAME_RST;
      en_q    <= 1'b0;
      ien     <= 2'b00;
    end else if (wr_en) begin
      if (addr == A_CTRL)  bl_sel  <= wdata[12];
      if (addr == A_FRAME) frame_q <= wdata & FRAME_MASK;
      if (addr == A_FEN)   ien     <= wdata[1:0];
      if (addr == A_CMD) begin
        if (wdata[3])      en_q <= 1'b0;
        else if (wdata[2]) en_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q[0] <= '0;
      buf_q[1] <= '0;
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (push) begin
        buf_q[wp] <= wdata[7:0];
        wp        <= ~wp;
      end
      if (load) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, load};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      stop_q    <= TW'(OSR);
    end else begin
      case (phase)
        S_IDLE: if (load) begin
          phase     <= S_BITS;
          sh        <= fv;
          bits_left <= nbits;
          tcnt      <= '0;
          stop_q    <= stop_len;
        end
        S_BITS: if (baud_tick) begin
          if (tcnt == TW'(OSR-1)) begin
            tcnt      <= '0;
            sh        <= {1'b1, sh[10:1]};
            bits_left <= bits_left - 4'd1;
            if (bits_left == 4'd1) phase <= S_STOP;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        default: if (baud_tick) begin
          if (done) begin
            phase <= S_IDLE;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_stat <= 1'b0;
      if_txc   <= 1'b0;
    end else begin
      if (wr_data)        txc_stat <= 1'b0;
      else if (cmp_event) txc_stat <= 1'b1;
      if (cmp_event)                           if_txc <= 1'b1;
      else if (wr_en && addr == A_FCLR && wdata[0]) if_txc <= 1'b0;
      else if (wr_en && addr == A_FSET && wdata[0]) if_txc <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {3'b000, bl_sel, 12'h000};
      A_FRAME: rdata = frame_q;
      A_STAT:  rdata = {9'h000, txbl, txc_stat, 3'b000, en_q, 1'b0};
      A_FLAG:  rdata = {14'h0000, txbl, if_txc};
      A_FEN:   rdata = {14'h0000, ien};
      default: rdata = 16'h0000;
    endcase
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);
  a_r5_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_IDLE && !en_q) |=> phase == S_IDLE);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_IDLE && en_q && cnt != 2'd0) |=> (phase == S_BITS && !tx_out));
  a_r8_complete_empty: assert property (@(posedge clk) disable iff (!rst_n)
    txc_stat |-> cnt == 2'd0);
  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |=> if_txc);
endmodule

// File: tb/test_uart_tx_port.sv
`timescale 1ns/1ps
module test_uart_tx_port;
  localparam int OSR = 16;
  localparam logic [3:0] A_CTRL = 0, A_FRAME = 1, A_CMD = 2, A_STAT = 3, A_DATA = 4,
                         A_FLAG = 5, A_FSET = 6, A_FCLR = 7, A_FEN = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = A_STAT;
  logic [15:0] wdata = '0, rdata;
  logic tx_out, irq, baud_tick, tick_seen;
  logic [31:0] cyc;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin cyc <= '0; tick_seen <= 1'b0; end
    else begin cyc <= cyc + 1; tick_seen <= baud_tick; end
  assign baud_tick = cyc[0];

  uart_tx_port #(.OSR(OSR), .AW(4)) i_uart_tx_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .baud_tick(baud_tick), .tx_out(tx_out), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = A_STAT;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #0.5 v = rdata; addr = A_STAT;
  endtask

  // expects one frame; checks every bit mid-period, the stop level and the end tick
  task automatic run_frame(input logic [7:0] d, input int dl, input int par,
                           input int stop_t, input bit exp_txc);
    int ticks, nb, p, tmo;
    bit started;
    nb = 1 + dl + (par >= 2 ? 1 : 0);
    p  = (par == 3) ? 1 : 0;
    for (int i = 0; i < dl; i++) p ^= d[i];
    started = 0; tmo = 0;
    while (!started && tmo < 4000) begin
      @(negedge clk); tmo++;
      if (tx_out == 1'b0) started = 1;
    end
    chk("R2 start bit seen", int'(started), 1);
    if (!started) return;
    ticks = 0;
    while (ticks < nb*OSR + stop_t) begin
      @(negedge clk);
      if (tick_seen) begin
        ticks++;
        for (int k = 0; k < nb; k++)
          if (ticks == k*OSR + OSR/2) begin
            if (k == 0) chk("R2 start level", int'(tx_out), 0);
            else if (k <= dl) chk("R2 data bit", int'(tx_out), int'(d[k-1]));
            else chk("R3 parity bit", int'(tx_out), p);
          end
        if (ticks == nb*OSR + stop_t/2) chk("R4 stop level", int'(tx_out), 1);
        if (ticks == nb*OSR + stop_t - 1) chk("R4 not done early", int'(rdata[5]), 0);
      end
    end
    chk("R8 complete at frame end", int'(rdata[5]), int'(exp_txc));
    chk("R4 line idle after frame", int'(tx_out), 1);
  endtask

  task automatic quiet(input int cycles);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!tx_out) lows++;
    end
    chk("R5/R6 line stays idle", lows, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int idx;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 tx idle", int'(tx_out), 1);
    chk("R1 irq low", int'(irq), 0);
    rd(A_STAT, v); chk("R1 status", int'(v), 16'h0040);
    rd(A_FLAG, v); chk("R1 flags", int'(v), 16'h0002);

    wr(A_CMD, 16'h0004);
    rd(A_STAT, v); chk("R5 enabled bit", int'(v[1]), 1);

    // R2 R3 R4 sweep of the format
    idx = 0;
    for (int dl = 5; dl <= 8; dl++)
      for (int pi = 0; pi < 3; pi++)
        for (int s = 0; s < 4; s++) begin
          int par, st;
          par = (pi == 0) ? 0 : pi + 1;
          st = (s == 0) ? OSR/2 : (s == 1) ? OSR : (s == 2) ? 3*OSR/2 : 2*OSR;
          d = 8'h5A ^ 8'(idx * 29);
          idx++;
          wr(A_FRAME, 16'((s << 12) | (par << 8) | (dl - 3)));
          wr(A_DATA, {8'h00, d});
          run_frame(d, dl, par, st, 1'b1);
        end
    // R2 out-of-range length code selects 8 bits; odd parity code 01 means none
    wr(A_FRAME, 16'h1100);
    wr(A_DATA, 16'h00C3);
    run_frame(8'hC3, 8, 0, OSR, 1'b1);

    // R5 both command bits: disable wins; R8 data write clears complete
    wr(A_CMD, 16'h000C);
    rd(A_STAT, v); chk("R5 disable wins", int'(v[1]), 0);
    chk("R8 complete before write", int'(v[5]), 1);
    wr(A_FRAME, 16'h1005);
    wr(A_DATA, 16'h0011);
    rd(A_STAT, v); chk("R8 cleared by write", int'(v[5]), 0);
    chk("R7 sel0 one entry", int'(v[6]), 0);
    wr(A_CTRL, 16'h1000);
    rd(A_STAT, v); chk("R7 sel1 one entry", int'(v[6]), 1);
    wr(A_DATA, 16'h0022);
    rd(A_STAT, v); chk("R7 sel1 full", int'(v[6]), 0);
    wr(A_DATA, 16'h0033);
    rd(A_STAT, v); chk("R6 still full", int'(v[6]), 0);
    wr(A_CTRL, 16'h0000);
    quiet(200);

    wr(A_CMD, 16'h0004);
    run_frame(8'h11, 8, 0, OSR, 1'b0);
    run_frame(8'h22, 8, 0, OSR, 1'b1);
    quiet(3 * 10 * OSR * 2);  // R6 dropped character never appears

    // R5 disable during a frame: it completes, the next one waits
    wr(A_CMD, 16'h0008);
    wr(A_DATA, 16'h0044);
    wr(A_DATA, 16'h0055);
    wr(A_CMD, 16'h0004);
    fork
      run_frame(8'h44, 8, 0, OSR, 1'b0);
      begin repeat (40) @(negedge clk); wr(A_CMD, 16'h0008); end
    join
    quiet(3 * 10 * OSR * 2);
    rd(A_STAT, v); chk("R5 off after disable", int'(v[1]), 0);
    chk("R8 not complete while buffered", int'(v[5]), 0);
    wr(A_CMD, 16'h0004);
    run_frame(8'h55, 8, 0, OSR, 1'b1);

    // R9 R10 flags and mask
    rd(A_FLAG, v); chk("R9 event set flag", int'(v[0]), 1);
    chk("R10 masked", int'(irq), 0);
    wr(A_FCLR, 16'h0001);
    rd(A_FLAG, v); chk("R9 clear alias", int'(v[0]), 0);
    wr(A_FEN, 16'h0001);
    chk("R10 enabled, no flag", int'(irq), 0);
    wr(A_FSET, 16'h0001);
    rd(A_FLAG, v); chk("R9 set alias", int'(v[0]), 1);
    chk("R10 flag and enable", int'(irq), 1);
    wr(A_FCLR, 16'h0001);
    chk("R10 cleared", int'(irq), 0);
    wr(A_FEN, 16'h0002);
    chk("R10 level flag", int'(irq), 1);
    wr(A_FCLR, 16'h0002);
    rd(A_FLAG, v); chk("R9 level ignores clear", int'(v[1]), 1);
    wr(A_FEN, 16'h0000);
    chk("R10 all masked", int'(irq), 0);
    wr(A_DATA, 16'h0066);
    run_frame(8'h66, 8, 0, OSR, 1'b1);
    rd(A_FLAG, v); chk("R9 frame event", int'(v[0]), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule